// File: doc/BRIEF.md
# Two-Stage Configurable Lane Shuffle

This block routes a square array of K×K data lanes between a bank of processing elements and a row of check units. Every cycle it applies a cascade of two permutations: first each row of lanes is reordered within itself, then each column is reordered within itself. Each row and each column has one fixed wired pattern. A single control bit picks, per row and per column, either that pattern or the identity. The K-bit row word and the K-bit column word change every cycle. They are read from two ROM-like lookup functions, indexed by a cycle counter that restarts at 0 on a start pulse. After the second stage, the K lanes of output row x feed check unit x.

Messages return from the check units on their own set of wires. The return path undoes the forward route: it applies the inverse column pattern and then the inverse row pattern. The return path takes its control from a three-cycle delay of the forward control, which matches the latency of the check-unit pipeline outside the block. Both data paths are combinational. Only the counter and the control delay line hold state.

Top module: `shuffle2d_net`

## Requirements
- R1: With row control bit x set, forward stage one moves the word in lane (x,y) to lane (x,(5·y+x+1) mod K). With the bit clear, the row passes unchanged.
- R2: With column control bit y set, forward stage two moves the word in lane (x,y) to lane ((x+2·y+3) mod K, y). With the bit clear, the column passes unchanged. Lane (x,y) is bits [(x·K+y)·W +: W] of a bus, and output row x goes to check unit x.
- R3: The word pair used at counter value a is row = low K bits of ((37·a+11) xor (a>>3)) and column = low K bits of ((23·a+45) xor (a>>3)). Bit x of the row word controls row x, and bit y of the column word controls column y. On a clock with en_i high and start_i low, the counter advances by one.
- R4: A clock with start_i high sets the counter to 0, whatever the value of en_i.
- R5: On a clock with en_i high and start_i low, the counter wraps from L-1 to 0.
- R6: On a clock with en_i and start_i both low, the counter holds, so the forward routing repeats.
- R7: The return path sends ret_i lane (x',y') to ret_o lane (x,y), where y' is the stage-one target of y and x' is the stage-two target of x in column y'. Each stage uses the return control bits, so the return path inverts the forward route.
- R8: The return control words equal the forward control words of three clocks earlier. Until three clocks have passed since reset, both return words are zero.
- R9: After reset the counter is 0, so the forward route uses the words for a=0 and the return route is the identity.
- R10: Every row pattern and every column pattern is a permutation of the K lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the control counter at 0 |
| en_i | input | 1 | Advance the control counter |
| fwd_i | input | K·K·FW | Forward words from the processing elements, one per lane |
| fwd_o | output | K·K·FW | Forward words to the check units, row x to unit x |
| ret_i | input | K·K·RW | Return messages from the check units |
| ret_o | output | K·K·RW | Return messages delivered to their source lanes |

## Verification
The bench keeps the full K=6 array and the default 6-bit and 5-bit lane widths. It shortens the counter to L=16, so a few hundred cycles run the counter through several full wraps. Those cycles also cover start pulses taken at arbitrary counter values and enable gaps. With this setup every one of the sixteen control-word pairs drives both paths many times, each time with a different lane data pattern. A sweep over all K row and column patterns confirms that each is a bijection. The first three cycles after reset expose the zeroed return control.

// File: rtl/shuffle2d_pkg.sv
package shuffle2d_pkg;

  // target lane of source lane j under a fixed pattern
  function automatic int perm_idx(input int j, input int step, input int ofs, input int n);
    return (j * step + ofs) % n;
  endfunction

  // control word at counter value a, before truncation to K bits
  function automatic logic [31:0] rom_word(input int a, input int mul, input int add);
    logic [31:0] v;
    v = 32'(a * mul + add) ^ (32'(a) >> 3);
    return v;
  endfunction

endpackage

// File: rtl/lane_perm.sv
module lane_perm #(
  parameter int N    = 6,
  parameter int W    = 6,
  parameter int STEP = 5,
  parameter int OFS  = 1,
  parameter bit INV  = 1'b0
) (
  input  logic                sel_i,
  input  logic [N-1:0][W-1:0] d_i,
  output logic [N-1:0][W-1:0] d_o
);
  import shuffle2d_pkg::*;

  generate
    if (INV) begin : g_inv
      always_comb begin
        d_o = d_i;
        if (sel_i)
          for (int j = 0; j < N; j++) d_o[j] = d_i[perm_idx(j, STEP, OFS, N)];
      end
    end else begin : g_fwd
      always_comb begin
        d_o = d_i;
        if (sel_i)
          for (int j = 0; j < N; j++) d_o[perm_idx(j, STEP, OFS, N)] = d_i[j];
      end
    end
  endgenerate
endmodule

// File: rtl/shuffle_ctrl.sv
module shuffle_ctrl #(
  parameter int K       = 6,
  parameter int L       = 256,
  parameter int DLY     = 3,
  parameter int ROW_MUL = 37,
  parameter int ROW_ADD = 11,
  parameter int COL_MUL = 23,
  parameter int COL_ADD = 45,
  localparam int AW     = (L > 1) ? $clog2(L) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic [K-1:0]  row_fwd_o,
  output logic [K-1:0]  col_fwd_o,
  output logic [K-1:0]  row_ret_o,
  output logic [K-1:0]  col_ret_o
);
  import shuffle2d_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(L - 1);

  logic [AW-1:0]          addr_q;
  logic [31:0]            row_raw, col_raw;
  logic [DLY-1:0][K-1:0]  row_dl_q, col_dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_q <= '0;
    else if (start_i)          addr_q <= '0;
    else if (en_i)             addr_q <= (addr_q == LAST) ? '0 : addr_q + AW'(1);
  end

  always_comb begin
    row_raw = rom_word(int'(addr_q), ROW_MUL, ROW_ADD);
    col_raw = rom_word(int'(addr_q), COL_MUL, COL_ADD);
  end

  assign row_fwd_o = row_raw[K-1:0];
  assign col_fwd_o = col_raw[K-1:0];

  // return control trails forward control by the outside pipeline depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_dl_q <= '0;
      col_dl_q <= '0;
    end else begin
      row_dl_q[0] <= row_fwd_o;
      col_dl_q[0] <= col_fwd_o;
      for (int i = 1; i < DLY; i++) begin
        row_dl_q[i] <= row_dl_q[i-1];
        col_dl_q[i] <= col_dl_q[i-1];
      end
    end
  end

  assign addr_o    = addr_q;
  assign row_ret_o = row_dl_q[DLY-1];
  assign col_ret_o = col_dl_q[DLY-1];
endmodule

// File: rtl/shuffle2d_net.sv
module shuffle2d_net #(
  parameter int K        = 6,
  parameter int FW       = 6,
  parameter int RW       = 5,
  parameter int L        = 256,
  parameter int DLY      = 3,
  parameter int ROW_STEP = 5,
  parameter int COL_STEP = 1,
  localparam int FBUS    = K * K * FW,
  localparam int RBUS    = K * K * RW,
  localparam int AW      = (L > 1) ? $clog2(L) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            en_i,
  input  logic [FBUS-1:0] fwd_i,
  output logic [FBUS-1:0] fwd_o,
  input  logic [RBUS-1:0] ret_i,
  output logic [RBUS-1:0] ret_o
);
  logic [AW-1:0] rom_addr;
  logic [K-1:0]  row_fwd, col_fwd, row_ret, col_ret;

  shuffle_ctrl #(.K(K), .L(L), .DLY(DLY)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .en_i,
    .addr_o(rom_addr), .row_fwd_o(row_fwd), .col_fwd_o(col_fwd),
    .row_ret_o(row_ret), .col_ret_o(col_ret)
  );

  // [row][col][bits]
  logic [K-1:0][K-1:0][FW-1:0] fa, fb, fc, fb_t, fc_t;
  logic [K-1:0][K-1:0][RW-1:0] ra, rb, rc, rb_t, rc_t;

  assign fa    = fwd_i;
  assign rc    = ret_i;
  assign fwd_o = fc;
  assign ret_o = ra;

  always_comb begin
    for (int x = 0; x < K; x++)
      for (int y = 0; y < K; y++) begin
        fb_t[y][x] = fb[x][y];
        fc[x][y]   = fc_t[y][x];
        rc_t[y][x] = rc[x][y];
        rb[x][y]   = rb_t[y][x];
      end
  end

  for (genvar x = 0; x < K; x++) begin : g_row
    lane_perm #(.N(K), .W(FW), .STEP(ROW_STEP), .OFS(x + 1), .INV(1'b0)) u_fwd (
      .sel_i(row_fwd[x]), .d_i(fa[x]), .d_o(fb[x]));
    lane_perm #(.N(K), .W(RW), .STEP(ROW_STEP), .OFS(x + 1), .INV(1'b1)) u_ret (
      .sel_i(row_ret[x]), .d_i(rb[x]), .d_o(ra[x]));
  end

  for (genvar y = 0; y < K; y++) begin : g_col
    lane_perm #(.N(K), .W(FW), .STEP(COL_STEP), .OFS(2 * y + 3), .INV(1'b0)) u_fwd (
      .sel_i(col_fwd[y]), .d_i(fb_t[y]), .d_o(fc_t[y]));
    lane_perm #(.N(K), .W(RW), .STEP(COL_STEP), .OFS(2 * y + 3), .INV(1'b1)) u_ret (
      .sel_i(col_ret[y]), .d_i(rc_t[y]), .d_o(rb_t[y]));
  end
endmodule

// File: rtl/shuffle2d_chk.sv
module shuffle2d_chk #(
  parameter int K   = 6,
  parameter int FW  = 6,
  parameter int RW  = 5,
  parameter int L   = 256,
  parameter int DLY = 3,
  localparam int AW = (L > 1) ? $clog2(L) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                en_i,
  input logic [AW-1:0]       addr,
  input logic [K-1:0]        row_fwd,
  input logic [K-1:0]        col_fwd,
  input logic [K-1:0]        row_ret,
  input logic [K-1:0]        col_ret,
  input logic [K*K*FW-1:0]   fwd_i,
  input logic [K*K*FW-1:0]   fwd_o,
  input logic [K*K*RW-1:0]   ret_i,
  input logic [K*K*RW-1:0]   ret_o
);
  logic [7:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  age_q <= '0;
    else if (age_q < 8'(DLY))     age_q <= age_q + 8'd1;
  end

  function automatic logic [FW-1:0] xf(input logic [K*K*FW-1:0] v);
    logic [FW-1:0] s = '0;
    for (int i = 0; i < K * K; i++) s ^= v[i*FW +: FW];
    return s;
  endfunction

  function automatic logic [RW-1:0] xr(input logic [K*K*RW-1:0] v);
    logic [RW-1:0] s = '0;
    for (int i = 0; i < K * K; i++) s ^= v[i*RW +: RW];
    return s;
  endfunction

  AST_ADDR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> addr == '0); // R4
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && en_i && addr == AW'(L - 1)) |=> addr == '0); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && en_i && addr != AW'(L - 1)) |=> addr == $past(addr) + AW'(1)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !en_i) |=> $stable(addr)); // R6
  AST_RET_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 8'(DLY)) |-> (row_ret == $past(row_fwd, DLY) && col_ret == $past(col_fwd, DLY))); // R8
  AST_FWD_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xf(fwd_o) == xf(fwd_i)); // R1
  AST_RET_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xr(ret_o) == xr(ret_i)); // R7
endmodule

bind shuffle2d_net shuffle2d_chk #(.K(K), .FW(FW), .RW(RW), .L(L), .DLY(DLY)) u_chk (
  .clk_i, .rst_ni, .start_i, .en_i,
  .addr(rom_addr), .row_fwd(row_fwd), .col_fwd(col_fwd),
  .row_ret(row_ret), .col_ret(col_ret),
  .fwd_i, .fwd_o, .ret_i, .ret_o
);

// File: tb/shuffle2d_net_test.sv
`timescale 1ns/1ps
module shuffle2d_net_test;
  localparam int K = 6, FW = 6, RW = 5, L = 16;
  localparam int FB = K * K * FW, RB = K * K * RW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, en = 1'b0;
  logic [FB-1:0] fwd_in, fwd_out;
  logic [RB-1:0] ret_in, ret_out;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  shuffle2d_net #(.K(K), .FW(FW), .RW(RW), .L(L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .en_i(en),
    .fwd_i(fwd_in), .fwd_o(fwd_out), .ret_i(ret_in), .ret_o(ret_out));

  // bench model state
  int m_addr = 0;
  logic [K-1:0] h_row [3], h_col [3];

  function automatic int prow(int x, int y); return (5 * y + x + 1) % K; endfunction
  function automatic int pcol(int y, int x); return (x + 2 * y + 3) % K; endfunction
  function automatic logic [K-1:0] wrow(int a);
    logic [31:0] v = 32'(37 * a + 11) ^ (32'(a) >> 3); return v[K-1:0];
  endfunction
  function automatic logic [K-1:0] wcol(int a);
    logic [31:0] v = 32'(23 * a + 45) ^ (32'(a) >> 3); return v[K-1:0];
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  task automatic step(input int p, input logic s, input logic e, input string tag);
    logic [FB-1:0] ef;
    logic [RB-1:0] er;
    logic [K-1:0] rw, cw;
    @(negedge clk);
    start = s; en = e;
    for (int i = 0; i < K * K; i++) begin
      fwd_in[i*FW +: FW] = FW'(i * 7 + p * 13 + (p >> 2));
      ret_in[i*RW +: RW] = RW'(i * 11 + p * 5 + 3);
    end
    #1;
    rw = wrow(m_addr); cw = wcol(m_addr);
    for (int x = 0; x < K; x++)
      for (int y = 0; y < K; y++) begin
        int y1 = rw[x] ? prow(x, y) : y;
        int x2 = cw[y1] ? pcol(y1, x) : x;
        ef[(x2 * K + y1) * FW +: FW] = fwd_in[(x * K + y) * FW +: FW];
      end
    for (int x = 0; x < K; x++)
      for (int y = 0; y < K; y++) begin
        int y1 = h_row[2][x] ? prow(x, y) : y;
        int x2 = h_col[2][y1] ? pcol(y1, x) : x;
        er[(x * K + y) * RW +: RW] = ret_in[(x2 * K + y1) * RW +: RW];
      end
    checks++;
    if (fwd_out !== ef) begin
      errors++;
      $display("FAIL %s R1 R2 R3 fwd addr=%0d actual %h expected %h", tag, m_addr, fwd_out, ef);
    end
    checks++;
    if (ret_out !== er) begin
      errors++;
      $display("FAIL %s R7 R8 ret actual %h expected %h", tag, ret_out, er);
    end
    @(posedge clk);
    h_row[2] = h_row[1]; h_row[1] = h_row[0]; h_row[0] = rw;
    h_col[2] = h_col[1]; h_col[1] = h_col[0]; h_col[0] = cw;
    if (s) m_addr = 0;
    else if (e) m_addr = (m_addr + 1) % L;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin h_row[i] = '0; h_col[i] = '0; end
    fwd_in = '0; ret_in = '0;

    // R10: every pattern is a bijection
    for (int r = 0; r < K; r++) begin
      int seen_r = 0, seen_c = 0;
      for (int j = 0; j < K; j++) begin
        seen_r |= 1 << prow(r, j);
        seen_c |= 1 << pcol(r, j);
      end
      checks++;
      if (seen_r != (1 << K) - 1 || seen_c != (1 << K) - 1) begin
        errors++;
        $display("FAIL R10 pattern %0d actual %h/%h expected %h", r, seen_r, seen_c, (1 << K) - 1);
      end
    end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state, identity return for the first three clocks
    for (int p = 0; p < 3; p++) step(p, 1'b0, 1'b1, "R9");
    // R3 R5: several wraps with varying data
    for (int p = 3; p < 60; p++) step(p, 1'b0, 1'b1, "R5");
    // R6: hold with enable low
    for (int p = 60; p < 66; p++) step(p, 1'b0, 1'b0, "R6");
    // R4: start pulses at several counter values, with and without enable
    for (int k = 0; k < 12; k++) begin
      step(100 + k, 1'b1, k[0], "R4");
      for (int p = 0; p < k + 3; p++) step(200 + k * 16 + p, 1'b0, (p % 4) != 3, "R4");
    end
    for (int p = 400; p < 440; p++) step(p, 1'b0, 1'b1, "R1");
    summary();
  end
endmodule